// File: doc/BRIEF.md
# In-Order Commit Queue with Operand Forwarding

This block keeps instructions that are in flight in program order so that results produced out of order reach the architectural registers in order. Each dispatch cycle may reserve up to two slots at the tail of an 8-slot circular queue. A slot records the destination register index. Later, a completion write that carries the slot's tag fills in the result and marks the slot done. Slots leave from the head, oldest first, at most two per cycle. A departing slot writes its value into a private bank of 16 architectural registers.

A read port looks up one register index and returns its most recent version. That version comes from the youngest queued slot that targets the register if such a slot exists, and from the architectural bank otherwise. When that youngest slot has no result yet, the port gives back its tag so a consumer can wait on it. A completion may carry a fault mark. When the faulting slot reaches the head, the whole queue is dropped and the slot's tag is reported as the restart point. The architectural bank then holds only the results of instructions older than the fault.

Top module: `inorder_commit_queue`

## Requirements
- R1: Dispatch lane 0 is the older lane. Requesting lanes take consecutive tags from the tail in lane order, and `disp_tag[l]` shows the tag lane l gets: tail plus the number of requesting lanes below l. If only lane 1 requests, it gets the tail tag.
- R2: `disp_ready` is low when the free slot count is smaller than the number of requesting lanes, or when a flush happens in the same cycle. A dispatch that is not accepted reserves no slot. A dispatch that exactly fills the queue is accepted.
- R3: A completion write with tag t stores its value in slot t and marks it done. Completions may arrive in any order.
- R4: Only the head slot may retire, and only once it is marked done. Done slots behind a pending head stay queued. A completion seen at an edge can retire the slot at the next edge at the earliest.
- R5: At most two slots retire per cycle. Retire lane 0 carries the older one, and `ret_valid` bit k marks lane k. Each retiring slot writes its value to its destination register. If both lanes name the same register, the lane 1 value remains.
- R6: When queued slots target the requested register, the read port answers from the one nearest the tail.
- R7: When no queued slot targets the requested register, the read port returns the architectural value with `rd_valid` high and `rd_tag` 0.
- R8: When the youngest matching slot is still pending, `rd_valid` is low and `rd_tag` gives that slot's tag.
- R9: A completion to the youngest matching slot in the same cycle as the read is forwarded: `rd_value` is the value being written, and `rd_valid` is high.
- R10: A head slot that is done and faulting raises `flush` for one cycle with `flush_tag` equal to its tag. That slot and every younger slot are discarded, and none of them writes an architectural register. The queue is empty afterwards.
- R11: After reset the queue is empty, every architectural register reads 0, and the first dispatch gets tags 0 and 1.
- R12: When an older done slot shares a cycle with a faulting slot, the older slot retires on its own lane and the faulting slot is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| disp_req | input | 2 | Per-lane dispatch request; bit 0 is the older lane |
| disp_dest | input | 2x4 | Destination register index per dispatch lane |
| disp_ready | output | 1 | Dispatch accepted this cycle |
| disp_tag | output | 2x3 | Tag given to each dispatch lane |
| cmp_valid | input | 1 | Completion write present |
| cmp_tag | input | 3 | Slot tag of the completion |
| cmp_value | input | 32 | Result value |
| cmp_fault | input | 1 | Completion carries a fault |
| rd_reg | input | 4 | Register index to look up |
| rd_value | output | 32 | Newest value of the register |
| rd_valid | output | 1 | `rd_value` holds a real result |
| rd_tag | output | 3 | Tag of the youngest matching slot, 0 when answered from the bank |
| ret_valid | output | 2 | Per-lane retire strobe; lane 0 is older |
| ret_dest | output | 2x4 | Destination register of each retiring slot |
| ret_value | output | 2x32 | Value written by each retiring slot |
| flush | output | 1 | Faulting head slot caused a discard |
| flush_tag | output | 3 | Tag of the faulting slot |

## Verification
The bench uses the default parameters: 8 slots, two dispatch lanes, two retire lanes and 16 registers. With only 8 slots, a few dispatch pairs fill the queue completely, which makes both the exact-fill accept and the full-queue reject reachable. The tags also wrap from 7 back to 0 while older slots are still queued. Two retire lanes cover the cases where only one lane fires because the slot behind it is pending or faulting, and the case where both lanes write the same register.

// File: rtl/icq_pkg.sv
package icq_pkg;

  localparam int ICQ_SLOTS   = 8;
  localparam int ICQ_LANES   = 2;
  localparam int ICQ_RETIRES = 2;
  localparam int ICQ_REGS    = 16;
  localparam int ICQ_DATA_W  = 32;

  // Which source answers an operand lookup.
  typedef enum logic [1:0] {
    RD_ARCH   = 2'd0,
    RD_ENTRY  = 2'd1,
    RD_BYPASS = 2'd2,
    RD_WAIT   = 2'd3
  } rd_src_e;

endpackage

// File: rtl/icq_ptrs.sv
module icq_ptrs #(
  parameter  int DEPTH = 8,
  parameter  int LANES = 2,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            disp_req,
  input  logic                        flush,
  input  logic [CNT_W-1:0]            ret_num,
  output logic [TAG_W-1:0]            head,
  output logic [TAG_W-1:0]            tail,
  output logic [CNT_W-1:0]            count,
  output logic                        disp_ok,
  output logic [LANES-1:0][TAG_W-1:0] disp_tag
);

  logic [TAG_W-1:0] head_nxt, tail_nxt;
  logic [CNT_W-1:0] count_nxt;
  logic             head_en, tail_en, count_en;

  always_comb begin
    int req_n;
    int pre_n;
    int add_n;
    req_n = 0;
    for (int l = 0; l < LANES; l++) begin
      req_n = req_n + int'(disp_req[l]);
    end
    disp_ok = !flush && ((DEPTH - int'(count)) >= req_n);
    pre_n = 0;
    for (int l = 0; l < LANES; l++) begin
      disp_tag[l] = TAG_W'((int'(tail) + pre_n) % DEPTH);
      pre_n = pre_n + int'(disp_req[l]);
    end
    add_n     = disp_ok ? req_n : 0;
    tail_nxt  = TAG_W'((int'(tail) + add_n) % DEPTH);
    head_nxt  = flush ? tail : TAG_W'((int'(head) + int'(ret_num)) % DEPTH);
    count_nxt = flush ? '0 : CNT_W'(int'(count) + add_n - int'(ret_num));
    tail_en   = (add_n != 0);
    head_en   = flush || (ret_num != '0);
    count_en  = tail_en || head_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (head_en)  head  <= head_nxt;
      if (tail_en)  tail  <= tail_nxt;
      if (count_en) count <= count_nxt;
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  a_r2_reject_keeps_tail: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_ok |=> $stable(tail));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && (head == tail));

  a_r5_retire_within_count: assert property (@(posedge clk) disable iff (!rst_n)
    ret_num <= count);

endmodule

// File: rtl/icq_retire_sel.sv
module icq_retire_sel #(
  parameter  int DEPTH = 8,
  parameter  int RETS  = 2,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [TAG_W-1:0]           head,
  input  logic [CNT_W-1:0]           count,
  input  logic [DEPTH-1:0]           done,
  input  logic [DEPTH-1:0]           fault,
  output logic [RETS-1:0]            ret_valid,
  output logic [RETS-1:0][TAG_W-1:0] ret_slot,
  output logic [CNT_W-1:0]           ret_num,
  output logic                       flush,
  output logic [TAG_W-1:0]           flush_tag
);

  always_comb begin
    logic chain;
    int   n;
    int   slot;
    chain = 1'b1;
    n     = 0;
    for (int k = 0; k < RETS; k++) begin
      slot         = (int'(head) + k) % DEPTH;
      ret_slot[k]  = TAG_W'(slot);
      ret_valid[k] = chain && (k < int'(count)) && done[slot] && !fault[slot];
      chain        = ret_valid[k];
      n            = n + int'(ret_valid[k]);
    end
    ret_num   = CNT_W'(n);
    flush     = (count != '0) && done[head] && fault[head];
    flush_tag = head;
  end

  for (genvar k = 1; k < RETS; k++) begin : g_order
    a_r4_retire_in_order: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid[k] |-> ret_valid[k-1]);
  end

  a_r10_fault_never_retires: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (ret_valid == '0));

endmodule

// File: rtl/icq_lookup.sv
module icq_lookup #(
  parameter  int DEPTH = 8,
  parameter  int REG_W = 4,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [TAG_W-1:0]            head,
  input  logic [CNT_W-1:0]            count,
  input  logic [DEPTH-1:0][REG_W-1:0] dest,
  input  logic [DEPTH-1:0]            done,
  input  logic [REG_W-1:0]            rd_reg,
  output logic                        hit,
  output logic [TAG_W-1:0]            hit_tag,
  output logic                        hit_done
);

  // Walk from oldest to youngest; later matches override earlier ones.
  always_comb begin
    int slot;
    hit     = 1'b0;
    hit_tag = '0;
    for (int j = 0; j < DEPTH; j++) begin
      slot = (int'(head) + j) % DEPTH;
      if ((j < int'(count)) && (dest[slot] == rd_reg)) begin
        hit     = 1'b1;
        hit_tag = TAG_W'(slot);
      end
    end
    hit_done = hit && done[hit_tag];
  end

  a_r6_hit_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (count != '0));

endmodule

// File: rtl/icq_archregs.sv
module icq_archregs #(
  parameter  int NREG   = 16,
  parameter  int DATA_W = 32,
  parameter  int WPORTS = 2,
  localparam int REG_W  = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [WPORTS-1:0]            we,
  input  logic [WPORTS-1:0][REG_W-1:0] waddr,
  input  logic [WPORTS-1:0][DATA_W-1:0] wdata,
  input  logic [REG_W-1:0]             raddr,
  output logic [DATA_W-1:0]            rdata
);

  logic [NREG-1:0][DATA_W-1:0] regs, regs_nxt;
  logic                        wr_en;

  // Higher port index is younger and is applied last.
  always_comb begin
    regs_nxt = regs;
    for (int k = 0; k < WPORTS; k++) begin
      if (we[k]) regs_nxt[waddr[k]] = wdata[k];
    end
    wr_en = |we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr_en) begin
      regs <= regs_nxt;
    end
  end

  assign rdata = regs[raddr];

  a_r5_youngest_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we[WPORTS-1] |=> regs[$past(waddr[WPORTS-1])] == $past(wdata[WPORTS-1]));

endmodule

// File: rtl/inorder_commit_queue.sv
module inorder_commit_queue
  import icq_pkg::*;
#(
  parameter  int DEPTH   = ICQ_SLOTS,
  parameter  int LANES   = ICQ_LANES,
  parameter  int RETS    = ICQ_RETIRES,
  parameter  int NREG    = ICQ_REGS,
  parameter  int DATA_W  = ICQ_DATA_W,
  localparam int TAG_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int REG_W   = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             disp_req,
  input  logic [LANES-1:0][REG_W-1:0]  disp_dest,
  output logic                         disp_ready,
  output logic [LANES-1:0][TAG_W-1:0]  disp_tag,
  input  logic                         cmp_valid,
  input  logic [TAG_W-1:0]             cmp_tag,
  input  logic [DATA_W-1:0]            cmp_value,
  input  logic                         cmp_fault,
  input  logic [REG_W-1:0]             rd_reg,
  output logic [DATA_W-1:0]            rd_value,
  output logic                         rd_valid,
  output logic [TAG_W-1:0]             rd_tag,
  output logic [RETS-1:0]              ret_valid,
  output logic [RETS-1:0][REG_W-1:0]   ret_dest,
  output logic [RETS-1:0][DATA_W-1:0]  ret_value,
  output logic                         flush,
  output logic [TAG_W-1:0]             flush_tag
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_q1, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1  <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_q1  <= 1'b1;
      rst_s_n <= rst_q1;
    end
  end

  logic [TAG_W-1:0]            head, tail;
  logic [CNT_W-1:0]            count;
  logic                        disp_ok;
  logic [LANES-1:0][TAG_W-1:0] lane_tag;
  logic [RETS-1:0]             sel_valid;
  logic [RETS-1:0][TAG_W-1:0]  sel_slot;
  logic [CNT_W-1:0]            sel_num;
  logic                        sel_flush;
  logic [TAG_W-1:0]            sel_flush_tag;

  logic [DEPTH-1:0][REG_W-1:0]  ent_dest, ent_dest_nxt;
  logic [DEPTH-1:0][DATA_W-1:0] ent_val, ent_val_nxt;
  logic [DEPTH-1:0]             ent_done, ent_done_nxt;
  logic [DEPTH-1:0]             ent_fault, ent_fault_nxt;
  logic                         cmp_we, disp_we, ent_en;

  icq_ptrs #(.DEPTH(DEPTH), .LANES(LANES)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .disp_req (disp_req),
    .flush    (sel_flush),
    .ret_num  (sel_num),
    .head     (head),
    .tail     (tail),
    .count    (count),
    .disp_ok  (disp_ok),
    .disp_tag (lane_tag)
  );

  icq_retire_sel #(.DEPTH(DEPTH), .RETS(RETS)) u_sel (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .head      (head),
    .count     (count),
    .done      (ent_done),
    .fault     (ent_fault),
    .ret_valid (sel_valid),
    .ret_slot  (sel_slot),
    .ret_num   (sel_num),
    .flush     (sel_flush),
    .flush_tag (sel_flush_tag)
  );

  assign disp_ready = disp_ok;
  assign disp_tag   = lane_tag;
  assign flush      = sel_flush;
  assign flush_tag  = sel_flush_tag;

  // Slot storage: next state
  always_comb begin
    ent_dest_nxt  = ent_dest;
    ent_val_nxt   = ent_val;
    ent_done_nxt  = ent_done;
    ent_fault_nxt = ent_fault;
    cmp_we        = cmp_valid && !sel_flush;
    disp_we       = disp_ok && (disp_req != '0);
    if (cmp_we) begin
      ent_val_nxt[cmp_tag]   = cmp_value;
      ent_done_nxt[cmp_tag]  = 1'b1;
      ent_fault_nxt[cmp_tag] = cmp_fault;
    end
    for (int l = 0; l < LANES; l++) begin
      if (disp_ok && disp_req[l]) begin
        ent_dest_nxt[lane_tag[l]]  = disp_dest[l];
        ent_done_nxt[lane_tag[l]]  = 1'b0;
        ent_fault_nxt[lane_tag[l]] = 1'b0;
      end
    end
    ent_en = cmp_we || disp_we;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ent_done  <= '0;
      ent_fault <= '0;
    end else if (ent_en) begin
      ent_done  <= ent_done_nxt;
      ent_fault <= ent_fault_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (ent_en) begin
      ent_dest <= ent_dest_nxt;
      ent_val  <= ent_val_nxt;
    end
  end

  // Retire lanes
  always_comb begin
    for (int k = 0; k < RETS; k++) begin
      ret_dest[k]  = ent_dest[sel_slot[k]];
      ret_value[k] = ent_val[sel_slot[k]];
    end
    ret_valid = sel_valid;
  end

  logic [DATA_W-1:0] arch_rdata;

  icq_archregs #(.NREG(NREG), .DATA_W(DATA_W), .WPORTS(RETS)) u_arch (
    .clk   (clk),
    .rst_n (rst_s_n),
    .we    (sel_valid),
    .waddr (ret_dest),
    .wdata (ret_value),
    .raddr (rd_reg),
    .rdata (arch_rdata)
  );

  // Operand read
  logic             hit, hit_done;
  logic [TAG_W-1:0] hit_tag;
  rd_src_e          rd_src;

  icq_lookup #(.DEPTH(DEPTH), .REG_W(REG_W)) u_lookup (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .head     (head),
    .count    (count),
    .dest     (ent_dest),
    .done     (ent_done),
    .rd_reg   (rd_reg),
    .hit      (hit),
    .hit_tag  (hit_tag),
    .hit_done (hit_done)
  );

  always_comb begin
    if (!hit)                                rd_src = RD_ARCH;
    else if (hit_done)                       rd_src = RD_ENTRY;
    else if (cmp_valid && cmp_tag == hit_tag) rd_src = RD_BYPASS;
    else                                     rd_src = RD_WAIT;
    unique case (rd_src)
      RD_ARCH: begin
        rd_value = arch_rdata;
        rd_valid = 1'b1;
        rd_tag   = '0;
      end
      RD_ENTRY: begin
        rd_value = ent_val[hit_tag];
        rd_valid = 1'b1;
        rd_tag   = hit_tag;
      end
      RD_BYPASS: begin
        rd_value = cmp_value;
        rd_valid = 1'b1;
        rd_tag   = hit_tag;
      end
      default: begin
        rd_value = '0;
        rd_valid = 1'b0;
        rd_tag   = hit_tag;
      end
    endcase
  end

  a_r3_fill_marks_done: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmp_valid && !sel_flush && !disp_we) |=> ent_done[$past(cmp_tag)]);

  a_r8_pending_read_not_valid: assert property (@(posedge clk) disable iff (!rst_s_n)
    (hit && !hit_done && !cmp_valid) |-> !rd_valid);

endmodule

// File: tb/inorder_commit_queue_bench.sv
module inorder_commit_queue_bench;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        disp_req;
  logic [1:0][3:0]   disp_dest;
  logic              disp_ready;
  logic [1:0][2:0]   disp_tag;
  logic              cmp_valid;
  logic [2:0]        cmp_tag;
  logic [31:0]       cmp_value;
  logic              cmp_fault;
  logic [3:0]        rd_reg;
  logic [31:0]       rd_value;
  logic              rd_valid;
  logic [2:0]        rd_tag;
  logic [1:0]        ret_valid;
  logic [1:0][3:0]   ret_dest;
  logic [1:0][31:0]  ret_value;
  logic              flush;
  logic [2:0]        flush_tag;

  int n_chk = 0;
  int n_err = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;

  inorder_commit_queue u_inorder_commit_queue (
    .clk(clk), .rst_n(rst_n),
    .disp_req(disp_req), .disp_dest(disp_dest), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value), .cmp_fault(cmp_fault),
    .rd_reg(rd_reg), .rd_value(rd_value), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .ret_valid(ret_valid), .ret_dest(ret_dest), .ret_value(ret_value),
    .flush(flush), .flush_tag(flush_tag)
  );

  typedef struct packed {
    logic [1:0]  disp;
    logic [3:0]  d0;
    logic [3:0]  d1;
    logic        cv;
    logic [2:0]  ctag;
    logic [31:0] cval;
    logic        cf;
    logic [3:0]  rreg;
    logic        rdy;
    logic [2:0]  t0;
    logic [2:0]  t1;
    logic        rv;
    logic [31:0] rval;
    logic [2:0]  rtag;
    logic [1:0]  ret;
    logic        fl;
    logic [2:0]  ftag;
    logic [3:0]  rq;
  } vec_t;

  // One row per cycle: inputs, then the outputs expected before the edge.
  localparam vec_t TBL [24] = '{
    // R1 first pair
    '{2'b11,4'd2,4'd4, 1'b0,3'd0,32'h0,1'b0, 4'd2, 1'b1,3'd0,3'd1, 1'b1,32'h0,3'd0, 2'b00,1'b0,3'd0, 4'd1},
    // R8 reg2 waits on tag0
    '{2'b11,4'd2,4'd5, 1'b0,3'd0,32'h0,1'b0, 4'd2, 1'b1,3'd2,3'd3, 1'b0,32'h0,3'd0, 2'b00,1'b0,3'd0, 4'd8},
    // R9 bypass into youngest reg2 (tag2)
    '{2'b00,4'd0,4'd0, 1'b1,3'd2,32'h33,1'b0, 4'd2, 1'b1,3'd0,3'd0, 1'b1,32'h33,3'd2, 2'b00,1'b0,3'd0, 4'd9},
    // R9 bypass reg5
    '{2'b00,4'd0,4'd0, 1'b1,3'd3,32'h55,1'b0, 4'd5, 1'b1,3'd0,3'd0, 1'b1,32'h55,3'd3, 2'b00,1'b0,3'd0, 4'd9},
    // R4 done slots wait behind pending head
    '{2'b00,4'd0,4'd0, 1'b0,3'd0,32'h0,1'b0, 4'd2, 1'b1,3'd0,3'd0, 1'b1,32'h33,3'd2, 2'b00,1'b0,3'd0, 4'd4},
    // R8 reg4 waits on tag1; head fills now
    '{2'b00,4'd0,4'd0, 1'b1,3'd0,32'h11,1'b0, 4'd4, 1'b1,3'd0,3'd0, 1'b0,32'h0,3'd1, 2'b00,1'b0,3'd0, 4'd8},
    // R4 head retires alone, next still pending
    '{2'b00,4'd0,4'd0, 1'b1,3'd1,32'h22,1'b0, 4'd4, 1'b1,3'd0,3'd0, 1'b1,32'h22,3'd1, 2'b01,1'b0,3'd0, 4'd4},
    // R5 two retire
    '{2'b00,4'd0,4'd0, 1'b0,3'd0,32'h0,1'b0, 4'd2, 1'b1,3'd0,3'd0, 1'b1,32'h33,3'd2, 2'b11,1'b0,3'd0, 4'd5},
    // R7 reg4 from bank
    '{2'b00,4'd0,4'd0, 1'b0,3'd0,32'h0,1'b0, 4'd4, 1'b1,3'd0,3'd0, 1'b1,32'h22,3'd0, 2'b01,1'b0,3'd0, 4'd7},
    // R7 reg5 from bank
    '{2'b00,4'd0,4'd0, 1'b0,3'd0,32'h0,1'b0, 4'd5, 1'b1,3'd0,3'd0, 1'b1,32'h55,3'd0, 2'b00,1'b0,3'd0, 4'd7},
    // R1 fill
    '{2'b11,4'd7,4'd7, 1'b0,3'd0,32'h0,1'b0, 4'd0, 1'b1,3'd4,3'd5, 1'b1,32'h0,3'd0, 2'b00,1'b0,3'd0, 4'd1},
    // R1 tags wrap next
    '{2'b11,4'd8,4'd9, 1'b0,3'd0,32'h0,1'b0, 4'd0, 1'b1,3'd6,3'd7, 1'b1,32'h0,3'd0, 2'b00,1'b0,3'd0, 4'd1},
    // R6 youngest reg7 is tag5
    '{2'b11,4'd10,4'd11, 1'b0,3'd0,32'h0,1'b0, 4'd7, 1'b1,3'd0,3'd1, 1'b0,32'h0,3'd5, 2'b00,1'b0,3'd0, 4'd6},
    // R2 exact fill accepted
    '{2'b11,4'd12,4'd13, 1'b0,3'd0,32'h0,1'b0, 4'd12, 1'b1,3'd2,3'd3, 1'b1,32'h0,3'd0, 2'b00,1'b0,3'd0, 4'd2},
    // R2 full: rejected
    '{2'b01,4'd1,4'd0, 1'b0,3'd0,32'h0,1'b0, 4'd12, 1'b0,3'd0,3'd0, 1'b0,32'h0,3'd2, 2'b00,1'b0,3'd0, 4'd2},
    // R9 younger reg7 fills first
    '{2'b00,4'd0,4'd0, 1'b1,3'd5,32'h77,1'b0, 4'd7, 1'b1,3'd0,3'd0, 1'b1,32'h77,3'd5, 2'b00,1'b0,3'd0, 4'd9},
    // R3 older one fills later
    '{2'b00,4'd0,4'd0, 1'b1,3'd4,32'h44,1'b0, 4'd7, 1'b1,3'd0,3'd0, 1'b1,32'h77,3'd5, 2'b00,1'b0,3'd0, 4'd3},
    // R5 both retire to reg7; queue still full
    '{2'b10,4'd0,4'd3, 1'b0,3'd0,32'h0,1'b0, 4'd7, 1'b0,3'd0,3'd0, 1'b1,32'h77,3'd5, 2'b11,1'b0,3'd0, 4'd5},
    // R1 lane 1 alone takes tail
    '{2'b10,4'd0,4'd3, 1'b0,3'd0,32'h0,1'b0, 4'd3, 1'b1,3'd0,3'd4, 1'b1,32'h0,3'd0, 2'b00,1'b0,3'd0, 4'd1},
    // R5 younger lane value kept in reg7
    '{2'b00,4'd0,4'd0, 1'b0,3'd0,32'h0,1'b0, 4'd7, 1'b1,3'd0,3'd0, 1'b1,32'h77,3'd0, 2'b00,1'b0,3'd0, 4'd5},
    // R9 faulting head completes
    '{2'b00,4'd0,4'd0, 1'b1,3'd6,32'h66,1'b1, 4'd8, 1'b1,3'd0,3'd0, 1'b1,32'h66,3'd6, 2'b00,1'b0,3'd0, 4'd9},
    // R10 flush, dispatch refused
    '{2'b11,4'd1,4'd1, 1'b1,3'd7,32'h99,1'b0, 4'd9, 1'b0,3'd0,3'd0, 1'b1,32'h99,3'd7, 2'b00,1'b1,3'd6, 4'd10},
    // R10 reg8 never written
    '{2'b00,4'd0,4'd0, 1'b0,3'd0,32'h0,1'b0, 4'd8, 1'b1,3'd0,3'd0, 1'b1,32'h0,3'd0, 2'b00,1'b0,3'd0, 4'd10},
    // R10 nothing allocated in flush cycle
    '{2'b11,4'd6,4'd6, 1'b0,3'd0,32'h0,1'b0, 4'd1, 1'b1,3'd5,3'd6, 1'b1,32'h0,3'd0, 2'b00,1'b0,3'd0, 4'd10}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    disp_req  = 2'b00;
    disp_dest = '0;
    cmp_valid = 1'b0;
    cmp_tag   = '0;
    cmp_value = '0;
    cmp_fault = 1'b0;
    rd_reg    = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R11 reset state
    @(negedge clk);
    rd_reg = 4'd5;
    #1;
    chk("R11", "disp_ready", 32'(disp_ready), 32'd1);
    chk("R11", "rd_value", rd_value, 32'h0);
    chk("R11", "rd_valid", 32'(rd_valid), 32'd1);
    chk("R11", "ret_valid", 32'(ret_valid), 32'd0);
    chk("R11", "flush", 32'(flush), 32'd0);

    foreach (TBL[i]) begin
      vec_t v;
      string rq;
      v = TBL[i];
      rq = $sformatf("R%0d row%0d", v.rq, i);
      @(negedge clk);
      disp_req  = v.disp;
      disp_dest = {v.d1, v.d0};
      cmp_valid = v.cv;
      cmp_tag   = v.ctag;
      cmp_value = v.cval;
      cmp_fault = v.cf;
      rd_reg    = v.rreg;
      #1;
      chk(rq, "disp_ready", 32'(disp_ready), 32'(v.rdy));
      if (v.rdy && v.disp[0]) chk(rq, "disp_tag0", 32'(disp_tag[0]), 32'(v.t0));
      if (v.rdy && v.disp[1]) chk(rq, "disp_tag1", 32'(disp_tag[1]), 32'(v.t1));
      chk(rq, "rd_valid", 32'(rd_valid), 32'(v.rv));
      if (v.rv) chk(rq, "rd_value", rd_value, v.rval);
      chk(rq, "rd_tag", 32'(rd_tag), 32'(v.rtag));
      chk(rq, "ret_valid", 32'(ret_valid), 32'(v.ret));
      chk(rq, "flush", 32'(flush), 32'(v.fl));
      if (v.fl) chk(rq, "flush_tag", 32'(flush_tag), 32'(v.ftag));
    end

    // R12: slots 5 (older, reg6) and 6 (younger, reg6) queued; 6 faults
    @(negedge clk);
    idle_inputs();
    cmp_valid = 1'b1; cmp_tag = 3'd6; cmp_value = 32'hA; cmp_fault = 1'b1;
    #1;
    chk("R12", "ret_valid pending head", 32'(ret_valid), 32'd0);
    @(negedge clk);
    cmp_tag = 3'd5; cmp_value = 32'hB; cmp_fault = 1'b0;
    #1;
    chk("R4", "ret_valid same-cycle fill", 32'(ret_valid), 32'd0);
    @(negedge clk);
    idle_inputs();
    #1;
    chk("R12", "ret_valid older only", 32'(ret_valid), 32'd1);
    chk("R12", "ret_dest0", 32'(ret_dest[0]), 32'd6);
    chk("R12", "ret_value0", ret_value[0], 32'hB);
    chk("R12", "flush", 32'(flush), 32'd0);
    @(negedge clk);
    #1;
    chk("R10", "flush", 32'(flush), 32'd1);
    chk("R10", "flush_tag", 32'(flush_tag), 32'd6);
    chk("R10", "ret_valid", 32'(ret_valid), 32'd0);
    @(negedge clk);
    rd_reg = 4'd6;
    #1;
    chk("R10", "reg6 keeps older value", rd_value, 32'hB);
    chk("R10", "reg6 valid", 32'(rd_valid), 32'd1);
    chk("R10", "flush cleared", 32'(flush), 32'd0);

    // R11: reset in mid-run clears queue and bank
    @(negedge clk);
    idle_inputs();
    disp_req = 2'b11; disp_dest = {4'd3, 4'd3};
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd_reg = 4'd2;
    #1;
    chk("R11", "reg2 after reset", rd_value, 32'h0);
    chk("R11", "reg2 valid after reset", 32'(rd_valid), 32'd1);
    @(negedge clk);
    rd_reg = 4'd3;
    disp_req = 2'b11; disp_dest = {4'd9, 4'd9};
    #1;
    chk("R11", "reg3 not queued", 32'(rd_tag), 32'd0);
    chk("R11", "disp_tag0", 32'(disp_tag[0]), 32'd0);
    chk("R11", "disp_tag1", 32'(disp_tag[1]), 32'd1);
    chk("R11", "disp_ready", 32'(disp_ready), 32'd1);
    @(negedge clk);
    idle_inputs();

    finish_run();
  end

endmodule